// File: doc/BRIEF.md
# Double-Width Integer Divider with Divide Trap

This block divides a dividend of twice the operand width by a divisor of one operand width. The operand width is 8, 16 or 32 bits and is picked per operation. Each operation is either unsigned or two's-complement signed. The dividend arrives as a high half and a low half, each one operand wide. The block returns a quotient and a remainder, each one operand wide. Signed quotients are truncated toward zero, and a signed remainder takes the sign of the dividend.

The unit works one quotient bit per clock, behind a start/busy/done handshake. A divisor of zero raises the trap output instead of producing a result. So does a quotient that cannot be represented at the selected width. In both cases the previous quotient and remainder stay on the outputs. A host pulses `start` with the operands and selects. It then waits for the single-cycle `done` and reads the quotient and remainder, or takes the trap indication.

Top module: `div_trap_unit`

## Requirements
- R1: In unsigned mode with a width of w bits, the dividend is D = {hiHalf[w-1:0], loHalf[w-1:0]} and the divisor is d = divisor[w-1:0]. The result is quotient = floor(D/d) and remainder = D mod d, placed in bits [w-1:0], with every output bit at or above w equal to zero.
- R2: When divisor[w-1:0] is zero, `done` pulses with `divTrap` high and no result is written.
- R3: In unsigned mode, hiHalf[w-1:0] >= divisor[w-1:0] means the quotient does not fit in w bits. This raises `divTrap`.
- R4: In signed mode (`signedOp` = 1), D and d are read as two's-complement values of 2w and w bits. The quotient is truncated toward zero.
- R5: In signed mode a nonzero remainder has the sign of D, and its magnitude is strictly below the magnitude of d.
- R6: In signed mode, a quotient below -2^(w-1) or above 2^(w-1)-1 raises `divTrap`. This includes the most negative dividend divided by -1.
- R7: When `divTrap` is raised, `quotient` and `remainder` keep the values they held before the operation.
- R8: Count rising edges from the one that samples `start`. `done` is high after edge w+2 when no early trap occurs. When the divisor is zero, or when the magnitude of D shifted right by w is at least the magnitude of d, `done` is high after edge 1.
- R9: After reset, `busy`, `done` and `divTrap` are low and `quotient` and `remainder` are zero. `busy` is high from the sampling edge until `done`, which lasts one cycle with `busy` low. A `start` seen while not idle is ignored.
- R10: `sizeSel` encoding: 0 selects 8 bits, 1 selects 16 bits, 2 and 3 both select 32 bits.
- R11: Operand bits at or above w in `hiHalf`, `loHalf` and `divisor` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| sizeSel | input | 2 | Operand width select |
| signedOp | input | 1 | 1 for two's-complement division |
| hiHalf | input | DATA_W | Upper half of the dividend |
| loHalf | input | DATA_W | Lower half of the dividend |
| divisor | input | DATA_W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| divTrap | output | 1 | Divide exception, valid with done |
| quotient | output | DATA_W | Quotient, zero-extended above w |
| remainder | output | DATA_W | Remainder, zero-extended above w |

## Verification
The assertions assume reset is applied before the first `start`. They also assume the operand registers only change on a load from idle, so the width and signedness seen at commit belong to the operation that is finishing. The stimulus meets this by driving every input half a cycle from the clock edge and holding `start` for exactly one cycle. The deliberate extra `start` pulses are sent only while the unit is busy or showing `done`. Under those conditions the bound and sign checks on the partial remainder and on the committed remainder must hold for every operand pattern the bench feeds.

// File: rtl/div_trap_pkg.sv
package div_trap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ITER,
    ST_FIX,
    ST_DONE
  } divState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands
    logic setup;   // magnitudes into the iteration registers
    logic step;    // one quotient bit
    logic commit;  // signed fixup and result write
  } dpStrobe_t;

  // Operand width for a size code: 0 -> quarter, 1 -> half, 2/3 -> full
  function automatic int unsigned sizeWidth(logic [1:0] sz, int unsigned dw);
    case (sz)
      2'd0:    return dw / 4;
      2'd1:    return dw / 2;
      default: return dw;
    endcase
  endfunction

endpackage

// File: rtl/div_trap_datapath.sv
module div_trap_datapath
  import div_trap_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        sizeSel,
  input  logic              signedOp,
  input  logic [DATA_W-1:0] hiHalf,
  input  logic [DATA_W-1:0] loHalf,
  input  logic [DATA_W-1:0] divisor,
  output logic              earlyErr,
  output logic              lateErr,
  output logic [CNT_W-1:0]  stepLimit,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder
);

  localparam int unsigned WIDE_W = 2 * DATA_W;

  // Latched operands
  logic [DATA_W-1:0] opHi, opLo, opDiv;
  logic [1:0]        opSize;
  logic              opSigned;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opHi     <= '0;
      opLo     <= '0;
      opDiv    <= '0;
      opSize   <= '0;
      opSigned <= 1'b0;
    end else if (strobe.load) begin
      opHi     <= hiHalf;
      opLo     <= loHalf;
      opDiv    <= divisor;
      opSize   <= sizeSel;
      opSigned <= signedOp;
    end
  end

  // Width-dependent masks
  int unsigned       opWidth;
  logic [DATA_W-1:0] opMask;
  logic [WIDE_W-1:0] wideMask;

  always_comb begin
    opWidth = sizeWidth(opSize, DATA_W);
    for (int i = 0; i < DATA_W; i++) opMask[i] = (i < opWidth) ? 1'b1 : 1'b0;
    for (int i = 0; i < WIDE_W; i++) wideMask[i] = (i < 2 * opWidth) ? 1'b1 : 1'b0;
  end

  assign stepLimit = CNT_W'(opWidth);

  // Magnitude preparation
  logic [WIDE_W-1:0] rawDvd, extDvd, magDvd, hiMag;
  logic [DATA_W-1:0] loMag, rawDvs, extDvs, magDvs;
  logic              dvdSign, dvsSign;

  always_comb begin
    rawDvd  = ({{DATA_W{1'b0}}, opHi & opMask} << opWidth)
            | {{DATA_W{1'b0}}, opLo & opMask};
    dvdSign = opSigned & rawDvd[2 * opWidth - 1];
    extDvd  = dvdSign ? (rawDvd | ~wideMask) : rawDvd;
    magDvd  = dvdSign ? (~extDvd + 1'b1) : extDvd;
    hiMag   = magDvd >> opWidth;
    loMag   = magDvd[DATA_W-1:0] & opMask;

    rawDvs  = opDiv & opMask;
    dvsSign = opSigned & rawDvs[opWidth - 1];
    extDvs  = dvsSign ? (rawDvs | ~opMask) : rawDvs;
    magDvs  = (dvsSign ? (~extDvs + 1'b1) : extDvs) & opMask;

    // zero divisor, or a quotient magnitude of 2^w or more
    earlyErr = (magDvs == '0) || (hiMag >= {{DATA_W{1'b0}}, magDvs});
  end

  // Iteration registers
  logic [DATA_W-1:0] remReg, qReg, dMagReg;
  logic              qNegReg, rNegReg;
  logic [DATA_W:0]   trial;
  logic              qBit;

  always_comb begin
    trial = {remReg, qReg[DATA_W-1]};
    qBit  = (trial >= {1'b0, dMagReg});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg  <= '0;
      qReg    <= '0;
      dMagReg <= '0;
      qNegReg <= 1'b0;
      rNegReg <= 1'b0;
    end else if (strobe.setup) begin
      remReg  <= hiMag[DATA_W-1:0];
      qReg    <= loMag << (DATA_W - opWidth);
      dMagReg <= magDvs;
      qNegReg <= dvdSign ^ dvsSign;
      rNegReg <= dvdSign;
    end else if (strobe.step) begin
      remReg <= qBit ? DATA_W'(trial - {1'b0, dMagReg}) : trial[DATA_W-1:0];
      qReg   <= {qReg[DATA_W-2:0], qBit};
    end
  end

  // Sign fixup and range check
  logic [DATA_W-1:0] posLimit, negLimit, qFinal, rFinal;

  always_comb begin
    posLimit = opMask >> 1;
    negLimit = posLimit + 1'b1;
    lateErr  = opSigned && (qNegReg ? (qReg > negLimit) : (qReg > posLimit));
    qFinal   = (qNegReg ? (~qReg + 1'b1) : qReg) & opMask;
    rFinal   = (rNegReg ? (~remReg + 1'b1) : remReg) & opMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient  <= '0;
      remainder <= '0;
    end else if (strobe.commit && !lateErr) begin
      quotient  <= qFinal;
      remainder <= rFinal;
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (remReg < dMagReg)); // R5

  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !lateErr && opSigned && (remReg != '0))
      |=> (remainder[stepLimit - 1'b1] == rNegReg)); // R5

endmodule

// File: rtl/div_trap_ctrl.sv
module div_trap_ctrl
  import div_trap_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             earlyErr,
  input  logic             lateErr,
  input  logic [CNT_W-1:0] stepLimit,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             done,
  output logic             divTrap
);

  divState_t        state, nextState;
  logic [CNT_W-1:0] stepCnt;
  logic             lastStep;

  assign lastStep = (stepCnt == stepLimit - 1'b1);

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:  if (start) nextState = ST_SETUP;
      ST_SETUP: nextState = earlyErr ? ST_DONE : ST_ITER;
      ST_ITER:  if (lastStep) nextState = ST_FIX;
      ST_FIX:   nextState = ST_DONE;
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.load   = (state == ST_IDLE) && start;
    strobe.setup  = (state == ST_SETUP);
    strobe.step   = (state == ST_ITER);
    strobe.commit = (state == ST_FIX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      divTrap <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_SETUP)     stepCnt <= '0;
      else if (state == ST_ITER) stepCnt <= stepCnt + 1'b1;
      if (strobe.load)                           divTrap <= 1'b0;
      else if ((state == ST_SETUP) && earlyErr)  divTrap <= 1'b1;
      else if ((state == ST_FIX) && lateErr)     divTrap <= 1'b1;
    end
  end

  assign busy = (state == ST_SETUP) || (state == ST_ITER) || (state == ST_FIX);
  assign done = (state == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done)); // R9

  AST_EARLY_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SETUP) && earlyErr) |=> (done && divTrap)); // R2

  AST_LATE_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_FIX) && lateErr) |=> (done && divTrap)); // R6

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ITER) |-> (stepCnt < stepLimit)); // R8

endmodule

// File: rtl/div_trap_unit.sv
module div_trap_unit
  import div_trap_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        sizeSel,
  input  logic              signedOp,
  input  logic [DATA_W-1:0] hiHalf,
  input  logic [DATA_W-1:0] loHalf,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic              divTrap,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  dpStrobe_t        strobe;
  logic             earlyErr, lateErr;
  logic [CNT_W-1:0] stepLimit;

  div_trap_ctrl #(.DATA_W(DATA_W)) ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .earlyErr (earlyErr),
    .lateErr  (lateErr),
    .stepLimit(stepLimit),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .divTrap  (divTrap)
  );

  div_trap_datapath #(.DATA_W(DATA_W)) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sizeSel  (sizeSel),
    .signedOp (signedOp),
    .hiHalf   (hiHalf),
    .loHalf   (loHalf),
    .divisor  (divisor),
    .earlyErr (earlyErr),
    .lateErr  (lateErr),
    .stepLimit(stepLimit),
    .quotient (quotient),
    .remainder(remainder)
  );

  AST_TRAP_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (done && divTrap) |-> ($stable(quotient) && $stable(remainder))); // R7

endmodule

// File: tb/div_trap_unit_test.sv
`timescale 1ns / 1ps
module div_trap_unit_test;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    sizeSel = '0;
  logic          signedOp = 1'b0;
  logic [DW-1:0] hiHalf = '0, loHalf = '0, divisor = '0;
  logic          busy, done, divTrap;
  logic [DW-1:0] quotient, remainder;

  always #4 clk = ~clk;  // 125 MHz

  div_trap_unit #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .sizeSel(sizeSel),
    .signedOp(signedOp), .hiHalf(hiHalf), .loHalf(loHalf), .divisor(divisor),
    .busy(busy), .done(done), .divTrap(divTrap),
    .quotient(quotient), .remainder(remainder)
  );

  typedef struct {
    logic [63:0] q;
    logic [63:0] r;
    bit          err;
    int          lat;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          checks = 0;
  int          errors = 0;
  int          negCount = 0;
  int          startNeg = 0;
  logic [63:0] prevQ = '0, prevR = '0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic item_t model(string tag, logic [1:0] sz, bit sgn,
                                  logic [31:0] hi, logic [31:0] lo, logic [31:0] dv);
    item_t       it;
    int          w;
    logic [63:0] m, m2, dd, d, dMagV, dvMag, qm, rm, lim;
    bit          dNeg, vNeg, qNeg, early, over;
    w     = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m     = (64'd1 << w) - 1;
    m2    = (w == 32) ? {64{1'b1}} : ((64'd1 << (2 * w)) - 1);
    dd    = ((({32'd0, hi}) & m) << w) | (({32'd0, lo}) & m);
    d     = {32'd0, dv} & m;
    dNeg  = sgn && dd[2 * w - 1];
    vNeg  = sgn && d[w - 1];
    dMagV = dNeg ? ((~dd + 64'd1) & m2) : dd;
    dvMag = vNeg ? ((~d + 64'd1) & m) : d;
    early = (dvMag == 0) || ((dMagV >> w) >= dvMag);
    over  = 1'b0;
    qm    = '0;
    rm    = '0;
    qNeg  = dNeg ^ vNeg;
    if (dvMag != 0) begin
      qm  = dMagV / dvMag;
      rm  = dMagV % dvMag;
      lim = !sgn ? m : (qNeg ? (64'd1 << (w - 1)) : ((64'd1 << (w - 1)) - 1));
      over = (qm > lim);
    end
    it.err = (dvMag == 0) || over;
    it.lat = early ? 1 : (w + 2);
    it.tag = tag;
    if (it.err) begin
      it.q = prevQ;
      it.r = prevR;
    end else begin
      it.q = qNeg ? ((~qm + 64'd1) & m) : qm;
      it.r = dNeg ? ((~rm + 64'd1) & m) : rm;
    end
    return it;
  endfunction

  // Driver: push expected item, pulse start, wait for the monitor to retire it
  task automatic runOp(string tag, logic [1:0] sz, bit sgn,
                       logic [31:0] hi, logic [31:0] lo, logic [31:0] dv, bit poke = 1'b0);
    item_t it;
    it = model(tag, sz, sgn, hi, lo, dv);
    if (!it.err) begin
      prevQ = it.q;
      prevR = it.r;
    end
    sbq.push_back(it);
    @(negedge clk);
    #1;
    sizeSel = sz; signedOp = sgn; hiHalf = hi; loHalf = lo; divisor = dv;
    start = 1'b1;
    startNeg = negCount;
    @(negedge clk);
    #1 start = 1'b0;
    if (poke) begin
      // R9: a second start while busy must not disturb the running operation
      @(negedge clk);
      #1;
      hiHalf = ~hi; loHalf = ~lo; divisor = dv ^ 32'h5; signedOp = ~sgn;
      start = 1'b1;
      @(negedge clk);
      #1 start = 1'b0;
    end
    while (sbq.size() != 0) @(negedge clk);
  endtask

  // Monitor
  initial begin
    forever begin
      item_t it;
      @(negedge clk);
      negCount++;
      if (done) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
        end else begin
          it = sbq.pop_front();
          check(divTrap == it.err, "R2/R3/R6", {it.tag, " trap"}, 64'(divTrap), 64'(it.err));
          check({32'd0, quotient} == it.q, "R1/R4/R7", {it.tag, " quotient"}, {32'd0, quotient}, it.q);
          check({32'd0, remainder} == it.r, "R1/R5/R7", {it.tag, " remainder"}, {32'd0, remainder}, it.r);
          check((negCount - startNeg - 1) == it.lat, "R8", {it.tag, " latency"},
                64'(negCount - startNeg - 1), 64'(it.lat));
          check(busy == 1'b0, "R9", {it.tag, " busy at done"}, 64'(busy), 64'd0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", sbq.size());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy && !done && !divTrap, "R9", "reset flags", {61'd0, busy, done, divTrap}, 64'd0);
    check(quotient == 0 && remainder == 0, "R9", "reset results", {quotient, remainder}, 64'd0);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done, "R9", "idle after reset", {62'd0, busy, done}, 64'd0);

    // R1 unsigned, each width
    runOp("R1 byte", 2'd0, 1'b0, 32'h12, 32'h34, 32'h56);
    runOp("R1 word", 2'd1, 1'b0, 32'h1234, 32'h5678, 32'h9abc);
    runOp("R1 long", 2'd2, 1'b0, 32'h0000_1234, 32'h5678_9abc, 32'h8765_4321);
    runOp("R1 long max", 2'd2, 1'b0, 32'hffff_fffe, 32'hffff_ffff, 32'hffff_ffff);
    runOp("R1 byte exact", 2'd0, 1'b0, 32'h00, 32'hc8, 32'h0a);
    // R11 upper bits ignored
    runOp("R11 byte", 2'd0, 1'b0, 32'habcd_ef12, 32'h7777_7734, 32'h1234_5656);
    runOp("R11 word", 2'd1, 1'b0, 32'hffff_0001, 32'h5a5a_0000, 32'h8000_0003);
    // R10 size code 3 acts as full width
    runOp("R10 code3", 2'd3, 1'b0, 32'h0000_0003, 32'h0000_0007, 32'h0001_0000);
    // R2 zero divisor, incl. nonzero bits only above width
    runOp("R2 byte", 2'd0, 1'b0, 32'h01, 32'h02, 32'h0000_0100);
    runOp("R2 long signed", 2'd2, 1'b1, 32'h0, 32'h9, 32'h0);
    // R3 unsigned range trap
    runOp("R3 equal", 2'd1, 1'b0, 32'h0042, 32'h0000, 32'h0042);
    runOp("R3 above", 2'd0, 1'b0, 32'hff, 32'hff, 32'h01);
    // R4 / R5 signed truncation and remainder sign
    runOp("R4 neg/pos", 2'd0, 1'b1, 32'hff, 32'hf9, 32'h02);
    runOp("R4 pos/neg", 2'd0, 1'b1, 32'h00, 32'h07, 32'hfe);
    runOp("R5 neg/neg", 2'd0, 1'b1, 32'hff, 32'hf9, 32'hfe);
    runOp("R5 word", 2'd1, 1'b1, 32'hfffe, 32'h1234, 32'h0100);
    runOp("R4 long", 2'd2, 1'b1, 32'hffff_ffff, 32'h8000_0001, 32'h0000_0007);
    runOp("R5 long", 2'd2, 1'b1, 32'h0000_0002, 32'h1111_1111, 32'hffff_fff3);
    // R6 signed range
    runOp("R6 minneg/-1", 2'd0, 1'b1, 32'h80, 32'h00, 32'hff);
    runOp("R6 255/1", 2'd0, 1'b1, 32'h00, 32'hff, 32'h01);
    runOp("R6 -128/1 ok", 2'd0, 1'b1, 32'hff, 32'h80, 32'h01);
    runOp("R6 -129/1", 2'd0, 1'b1, 32'hff, 32'h7f, 32'h01);
    runOp("R6 128/-1 ok", 2'd0, 1'b1, 32'h00, 32'h80, 32'hff);
    runOp("R6 long minneg", 2'd2, 1'b1, 32'h8000_0000, 32'h0, 32'hffff_ffff);
    // R7 trap after a good result keeps it
    runOp("R7 good", 2'd1, 1'b0, 32'h0001, 32'h0000, 32'h0003);
    runOp("R7 trap", 2'd1, 1'b0, 32'h0001, 32'h0000, 32'h0000);
    // R9 start while busy ignored
    runOp("R9 poke", 2'd1, 1'b1, 32'hffff, 32'h8001, 32'h0013, 1'b1);
    runOp("R9 after", 2'd0, 1'b0, 32'h03, 32'h21, 32'h07);

    repeat (3) @(negedge clk);
    check(!busy && !done, "R9", "final idle", {62'd0, busy, done}, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule